// File: doc/BRIEF.md
# Bit Timing and Resynchronization Unit

This block sets the pace at which one node of a differential serial bus samples the line. A programmable prescaler divides the system clock down to a time quantum. Every bit is then built from a fixed single-quantum sync slot followed by a propagation slot, a first phase slot and a second phase slot. Each slot length is programmable in quanta. The block raises a bit-start strobe for one quantum when a bit begins. It raises a sample strobe for one quantum when the first phase slot ends, and at that point it latches the line level.

The received line is compared from one quantum to the next. A recessive-to-dominant change is an edge. While the frame logic reports the bus as idle, an edge hard-synchronizes the bit timing. Otherwise the block measures how far the edge lies from the sync slot and corrects for it. A late edge lengthens the first phase slot. An early edge shortens the second phase slot, or ends the bit and uses the edge quantum as the next sync slot. Each correction is clamped to a programmable jump width. Frame decoding and bit stuffing belong to the logic that consumes `sample_pt` and `rx_bit`.

Top module: `bit_timing`

## Requirements
- R1: A quantum lasts `cfg_brp`+1 clock cycles. `tq_tick` is high for exactly one clock at the last cycle of every quantum, and all segment state moves only on that cycle.
- R2: With no edges, a bit lasts 1 + `cfg_prop` + `cfg_ph1` + `cfg_ph2` quanta (each field ≥ 1). The quantum right after reset is a sync slot. `bit_start` is high for the whole sync quantum of every later bit.
- R3: `sample_pt` is high for the one quantum that follows the last quantum of the first phase slot. At the same time `rx_bit` takes the line level seen during that last quantum (1 = recessive, 0 = dominant) and holds it until the next sample.
- R4: Only a change from 1 in one quantum to 0 in the next counts as an edge. A change from 0 to 1 never alters the timing.
- R5: While `bus_idle` is 1, an edge hard-synchronizes the timing. The quantum holding the edge becomes the sync slot, so the next quantum is the first propagation quantum with `bit_start` high, and all slot lengths return to their programmed values.
- R6: While `bus_idle` is 0, an edge never hard-synchronizes.
- R7: An edge inside the sync slot causes no correction.
- R8: An edge in the propagation slot or the first phase slot is late by e quanta, where e counts the quanta from the sync slot to the edge quantum. The first phase slot of that bit grows by min(e, `cfg_sjw`).
- R9: An edge in the second phase slot is early by m quanta, where m counts from the edge quantum to the end of that slot, inclusive. If m ≤ `cfg_sjw`, the bit ends at the edge quantum, the edge quantum serves as the next sync slot, and the following quantum starts a propagation slot with `bit_start` high.
- R10: If an early edge has m > `cfg_sjw`, the second phase slot is shortened by `cfg_sjw` quanta and the next bit starts with a normal sync slot.
- R11: At most one correction is applied per bit. Further edges in the same bit have no effect.
- R12: No correction is made on an edge while the last sampled value in `rx_bit` is dominant.
- R13: During reset `tq_tick`, `bit_start` and `sample_pt` are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_brp | input | BRP_W | Prescaler; quantum = cfg_brp+1 clocks |
| cfg_prop | input | SEG_W | Propagation slot length in quanta |
| cfg_ph1 | input | SEG_W | First phase slot length in quanta |
| cfg_ph2 | input | SEG_W | Second phase slot length in quanta |
| cfg_sjw | input | SEG_W | Maximum correction per bit in quanta |
| bus_idle | input | 1 | 1 while the frame logic sees an idle bus; enables hard sync |
| rx | input | 1 | Received line level, 1 recessive, 0 dominant |
| tq_tick | output | 1 | One-clock pulse closing each quantum |
| bit_start | output | 1 | High for the quantum that opens a bit |
| sample_pt | output | 1 | High for the quantum after the sample point |
| rx_bit | output | 1 | Line level latched at the latest sample point |

## Verification
A wrong segment counter, a mis-clamped correction or a skipped sync slot shows up at the ports as a `sample_pt` or `bit_start` in the wrong quantum. Such a fault appears within the bit that contains the stimulating edge, or at the latest in the bit after it. Once a bit boundary moves, every later strobe stays shifted. For that reason each strobe is checked against its exact quantum index, and every unexpected strobe counts as a miscompare. A wrong latched level shows in `rx_bit` during the very quantum in which `sample_pt` rises.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int BRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    output logic             tick_o
);

    logic [BRP_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap   = (cnt_q >= cfg_brp);
        cnt_d  = wrap ? '0 : cnt_q + BRP_W'(1);
        tick_o = wrap && rst_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bt_edge_det.sv
module bt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx,
    output logic lvl_o,
    output logic fall_o
);

    typedef struct packed {
        logic line;   // registered line level
        logic prev;   // level held over the previous quantum
    } ed_t;

    ed_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.line = rx;
        if (tick_i) st_d.prev = st_q.line;
        lvl_o  = st_q.line;
        fall_o = tick_i && st_q.prev && !st_q.line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.line <= 1'b1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bt_phase_err.sv
module bt_phase_err #(
    parameter int SEG_W = 4,
    localparam int LEN_W = SEG_W + 1,
    localparam int ERR_W = LEN_W + 1
) (
    input  bt_pkg::seg_e     seg_i,
    input  logic [LEN_W-1:0] qcnt_i,
    input  logic [LEN_W-1:0] ph2_len_i,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_sjw,
    output logic             late_o,
    output logic             early_o,
    output logic [SEG_W-1:0] adj_o,
    output logic             full_o
);
    import bt_pkg::*;

    localparam logic [ERR_W-1:0] E_ONE = ERR_W'(1);

    logic [ERR_W-1:0] e_late;
    logic [ERR_W-1:0] e_early;
    logic [ERR_W-1:0] mag;
    logic [ERR_W-1:0] sjw_ext;

    always_comb begin
        late_o  = (seg_i == SEG_PROP) || (seg_i == SEG_PH1);
        early_o = (seg_i == SEG_PH2);
        // late distance counted from the sync slot to the edge quantum
        if (seg_i == SEG_PROP) e_late = ERR_W'(qcnt_i) + E_ONE;
        else                   e_late = ERR_W'(cfg_prop) + ERR_W'(qcnt_i) + E_ONE;
        // early distance counted from the edge quantum to the end of phase 2
        e_early = ERR_W'(ph2_len_i) - ERR_W'(qcnt_i);
        mag     = late_o ? e_late : (early_o ? e_early : '0);
        sjw_ext = ERR_W'(cfg_sjw);
        full_o  = (mag <= sjw_ext);
        adj_o   = full_o ? mag[SEG_W-1:0] : cfg_sjw;
    end

endmodule

// File: rtl/bt_seq.sv
module bt_seq #(
    parameter int SEG_W = 4,
    localparam int LEN_W = SEG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             fall_i,
    input  logic             lvl_i,
    input  logic             bus_idle,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SEG_W-1:0] cfg_sjw,
    output logic             bit_start,
    output logic             sample_pt,
    output logic             rx_bit
);
    import bt_pkg::*;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        seg_e             seg;
        logic [LEN_W-1:0] qcnt;
        logic [LEN_W-1:0] ph1_len;
        logic [LEN_W-1:0] ph2_len;
        logic             resynced;
        logic             bit_start;
        logic             sample_pt;
        logic             rx_bit;
    } seq_t;

    seq_t st_d, st_q;

    logic             late, early, full;
    logic [SEG_W-1:0] adj;
    logic             hard, resync;
    logic [LEN_W-1:0] ph1_eff, ph2_eff, qnext;

    bt_phase_err #(.SEG_W(SEG_W)) u_err (
        .seg_i     (st_q.seg),
        .qcnt_i    (st_q.qcnt),
        .ph2_len_i (st_q.ph2_len),
        .cfg_prop  (cfg_prop),
        .cfg_sjw   (cfg_sjw),
        .late_o    (late),
        .early_o   (early),
        .adj_o     (adj),
        .full_o    (full)
    );

    always_comb begin
        hard    = fall_i && bus_idle;
        resync  = fall_i && !bus_idle && !st_q.resynced && st_q.rx_bit && (late || early);
        ph1_eff = resync ? st_q.ph1_len + LEN_W'(adj) : st_q.ph1_len;
        ph2_eff = resync ? st_q.ph2_len - LEN_W'(adj) : st_q.ph2_len;
        qnext   = st_q.qcnt + ONE;

        st_d = st_q;
        if (tick_i) begin
            st_d.bit_start = 1'b0;
            st_d.sample_pt = 1'b0;
            if (hard) begin
                st_d.seg       = SEG_PROP;
                st_d.qcnt      = '0;
                st_d.ph1_len   = {1'b0, cfg_ph1};
                st_d.ph2_len   = {1'b0, cfg_ph2};
                st_d.resynced  = 1'b1;
                st_d.bit_start = 1'b1;
            end else begin
                unique case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg     = SEG_PROP;
                        st_d.qcnt    = '0;
                        st_d.ph1_len = {1'b0, cfg_ph1};
                        st_d.ph2_len = {1'b0, cfg_ph2};
                    end
                    SEG_PROP: begin
                        if (resync) begin
                            st_d.ph1_len  = ph1_eff;
                            st_d.resynced = 1'b1;
                        end
                        if (qnext >= {1'b0, cfg_prop}) begin
                            st_d.seg  = SEG_PH1;
                            st_d.qcnt = '0;
                        end else begin
                            st_d.qcnt = qnext;
                        end
                    end
                    SEG_PH1: begin
                        if (resync) begin
                            st_d.ph1_len  = ph1_eff;
                            st_d.resynced = 1'b1;
                        end
                        if (qnext >= ph1_eff) begin
                            st_d.seg       = SEG_PH2;
                            st_d.qcnt      = '0;
                            st_d.sample_pt = 1'b1;
                            st_d.rx_bit    = lvl_i;
                        end else begin
                            st_d.qcnt = qnext;
                        end
                    end
                    SEG_PH2: begin
                        if (resync && full) begin
                            // edge quantum stands in for the sync slot
                            st_d.seg       = SEG_PROP;
                            st_d.qcnt      = '0;
                            st_d.ph1_len   = {1'b0, cfg_ph1};
                            st_d.ph2_len   = {1'b0, cfg_ph2};
                            st_d.resynced  = 1'b1;
                            st_d.bit_start = 1'b1;
                        end else begin
                            if (resync) begin
                                st_d.ph2_len  = ph2_eff;
                                st_d.resynced = 1'b1;
                            end
                            if (qnext >= ph2_eff) begin
                                st_d.seg       = SEG_SYNC;
                                st_d.qcnt      = '0;
                                st_d.resynced  = 1'b0;
                                st_d.bit_start = 1'b1;
                            end else begin
                                st_d.qcnt = qnext;
                            end
                        end
                    end
                    default: st_d = st_q;
                endcase
            end
        end
        bit_start = st_q.bit_start;
        sample_pt = st_q.sample_pt;
        rx_bit    = st_q.rx_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seg       <= SEG_SYNC;
            st_q.qcnt      <= '0;
            st_q.ph1_len   <= ONE;
            st_q.ph2_len   <= ONE;
            st_q.resynced  <= 1'b0;
            st_q.bit_start <= 1'b0;
            st_q.sample_pt <= 1'b0;
            st_q.rx_bit    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bit_timing.sv
module bit_timing #(
    parameter int BRP_W = 8,
    parameter int SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SEG_W-1:0] cfg_sjw,
    input  logic             bus_idle,
    input  logic             rx,
    output logic             tq_tick,
    output logic             bit_start,
    output logic             sample_pt,
    output logic             rx_bit
);

    logic lvl, fall;

    bt_prescaler #(.BRP_W(BRP_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_brp (cfg_brp),
        .tick_o  (tq_tick)
    );

    bt_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tq_tick),
        .rx     (rx),
        .lvl_o  (lvl),
        .fall_o (fall)
    );

    bt_seq #(.SEG_W(SEG_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tq_tick),
        .fall_i    (fall),
        .lvl_i     (lvl),
        .bus_idle  (bus_idle),
        .cfg_prop  (cfg_prop),
        .cfg_ph1   (cfg_ph1),
        .cfg_ph2   (cfg_ph2),
        .cfg_sjw   (cfg_sjw),
        .bit_start (bit_start),
        .sample_pt (sample_pt),
        .rx_bit    (rx_bit)
    );

endmodule

// File: rtl/bt_chk.sv
module bt_chk #(
    parameter int BRP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BRP_W-1:0] cfg_brp,
    input logic             tq_tick,
    input logic             bit_start,
    input logic             sample_pt,
    input logic             rx_bit
);

    // R1: with a divider above one, a tick never lasts two clocks
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && cfg_brp != '0) |=> !tq_tick);

    // R1: segment strobes only move on a quantum boundary
    a_r1_bs_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tq_tick) |-> $stable(bit_start));

    a_r3_sp_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tq_tick) |-> $stable(sample_pt));

    // R3: the latched level changes only as a sample strobe opens
    a_r3_rxbit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> $rose(sample_pt));

    // R2: a bit opening and a sample point never share a quantum
    a_r2_bs_sp_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_start && sample_pt));

endmodule

bind bit_timing bt_chk #(.BRP_W(BRP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_brp   (cfg_brp),
    .tq_tick   (tq_tick),
    .bit_start (bit_start),
    .sample_pt (sample_pt),
    .rx_bit    (rx_bit)
);

// File: tb/sim_bit_timing.sv
`timescale 1ns/100ps
module sim_bit_timing;
    localparam int BRP_W = 8;
    localparam int SEG_W = 4;
    localparam int LAST_Q = 115;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic bus_idle = 1'b1;
    logic [BRP_W-1:0] cfg_brp = 8'd4;
    logic [SEG_W-1:0] cfg_prop = 4'd2, cfg_ph1 = 4'd3, cfg_ph2 = 4'd3, cfg_sjw = 4'd2;
    logic tq_tick, bit_start, sample_pt, rx_bit;

    always #2.5 clk = ~clk;

    bit_timing #(.BRP_W(BRP_W), .SEG_W(SEG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop),
        .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
        .bus_idle(bus_idle), .rx(rx), .tq_tick(tq_tick),
        .bit_start(bit_start), .sample_pt(sample_pt), .rx_bit(rx_bit)
    );

    typedef struct { int q; logic v; string tag; } exp_t;
    exp_t bs_q[$];
    exp_t sp_q[$];
    int n_chk = 0, n_bad = 0;
    bit run_go = 1'b0, mon_done = 1'b0, finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_bs(input int q, input string tag);
        exp_t e; e.q = q; e.v = 1'b1; e.tag = tag; bs_q.push_back(e);
    endtask

    task automatic push_sp(input int q, input logic v, input string tag);
        exp_t e; e.q = q; e.v = v; e.tag = tag; sp_q.push_back(e);
    endtask

    // wait until just after the clock edge that closes a quantum
    task automatic step_q();
        @(negedge clk);
        while (!tq_tick) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    // line level driven during each quantum (1 recessive, 0 dominant)
    function automatic logic rx_at(input int q);
        if (q >= 30 && q <= 35) return 1'b0;                   // hard sync, dominant bit
        if (q == 38) return 1'b0;                              // R12 blocked edge
        if (q == 49 || q == 50 || q == 52) return 1'b0;        // R8 late by 1, R11 second edge
        if (q == 62 || q == 69 || q == 86 || q == 101) return 1'b0;
        return 1'b1;
    endfunction

    // scoreboard driver: expected strobe quanta
    task automatic load_expect();
        push_bs(9,  "R2");        push_sp(6,   1'b1, "R3");
        push_bs(18, "R2");        push_sp(15,  1'b1, "R3");
        push_bs(27, "R2");        push_sp(24,  1'b1, "R3");
        push_bs(31, "R5");        push_sp(36,  1'b0, "R5 R3");
        push_bs(39, "R12");       push_sp(45,  1'b1, "R12");
        push_bs(48, "R2");        push_sp(55,  1'b1, "R8 R11");
        push_bs(58, "R8 R11");    push_sp(66,  1'b1, "R8 R6");
        push_bs(69, "R8");        push_sp(75,  1'b1, "R7 R4");
        push_bs(78, "R7 R6");     push_sp(84,  1'b1, "R9");
        push_bs(87, "R9");        push_sp(92,  1'b1, "R9");
        push_bs(95, "R9");        push_sp(101, 1'b1, "R10");
        push_bs(102, "R10");      push_sp(108, 1'b1, "R10");
        push_bs(111, "R10");
    endtask

    // monitor: pop and compare as strobes appear
    initial begin
        int mq;
        wait (run_go);
        mq = 0;
        while (mq < LAST_Q) begin
            step_q();
            mq++;
            if (bs_q.size() > 0 && bs_q[0].q == mq) begin
                chk(bit_start === 1'b1, {bs_q[0].tag, " bit_start at expected quantum"}, int'(bit_start), 1);
                void'(bs_q.pop_front());
            end else if (bit_start !== 1'b0) begin
                chk(1'b0, "R2 bit_start in unexpected quantum", mq, -1);
            end
            if (sp_q.size() > 0 && sp_q[0].q == mq) begin
                chk(sample_pt === 1'b1, {sp_q[0].tag, " sample_pt at expected quantum"}, int'(sample_pt), 1);
                chk(rx_bit === sp_q[0].v, {sp_q[0].tag, " sampled level"}, int'(rx_bit), int'(sp_q[0].v));
                void'(sp_q.pop_front());
            end else if (sample_pt !== 1'b0) begin
                chk(1'b0, "R3 sample_pt in unexpected quantum", mq, -1);
            end
        end
        mon_done = 1'b1;
    end

    // stimulus
    initial begin
        int gap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tq_tick === 1'b0,   "R13 tq_tick in reset",   int'(tq_tick), 0);
        chk(bit_start === 1'b0, "R13 bit_start in reset", int'(bit_start), 0);
        chk(sample_pt === 1'b0, "R13 sample_pt in reset", int'(sample_pt), 0);
        chk(rx_bit === 1'b1,    "R13 rx_bit in reset",    int'(rx_bit), 1);

        rst_n = 1'b1;
        while (!tq_tick) @(negedge clk);
        @(negedge clk);
        chk(tq_tick === 1'b0, "R1 tick lasts one clock", int'(tq_tick), 0);
        gap = 1;
        while (!tq_tick) begin @(negedge clk); gap++; end
        chk(gap == 5, "R1 quantum length with divider 4", gap, 5);

        rst_n = 1'b0;
        cfg_brp = 8'd1;
        rx = 1'b1;
        bus_idle = 1'b1;
        repeat (2) @(posedge clk);
        load_expect();
        @(negedge clk);
        rst_n = 1'b1;
        run_go = 1'b1;
        for (int qn = 1; qn <= LAST_Q; qn++) begin
            step_q();
            rx = rx_at(qn);
            bus_idle = (qn < 31);
        end
        wait (mon_done);
        chk(bs_q.size() == 0, "R2 all bit_start strobes seen", bs_q.size(), 0);
        chk(sp_q.size() == 0, "R3 all sample strobes seen", sp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule